// File: doc/BRIEF.md
# Bitmap-Redirected Vector Add Sequencer

This block executes one add instruction, written in scalar form, as a series of element adds across groups of physical registers. Each of the three operand fields (destination, first source, second source) names an architectural register, but that name does not select a physical register directly. It selects a 32-bit membership bitmap. Bit k of the bitmap says that physical register k belongs to the group. A cursor for each operand walks the set bits of its bitmap, wrapping around. Each element of the instruction can therefore land on a different physical register.

Software loads the bitmaps through a small write port while the sequencer is idle. A test port preloads and reads the 32-entry register file. A start pulse carries the three operand fields. The block holds `busy` high while it runs, completes one element per clock, and then raises `done` for one cycle. If any bitmap that the instruction uses is empty, the instruction ends at once with an error flag.

Top module: `bmvadd_seq`

## Requirements
- R1: After reset, bitmap k holds only bit k (identity grouping), every register-file entry reads zero, and `busy`, `done` and `err` are low.
- R2: A bitmap write (`map_we`) while idle replaces the bitmap of architectural register `map_sel` with `map_bits`. A bitmap write while `busy` is high has no effect.
- R3: The number of elements in an instruction equals the number of set bits in the destination operand's bitmap, and `busy` stays high for exactly that many cycles.
- R4: Every instruction clears all three operand cursors to 0. Each operand resolves to the first set bit of its bitmap found by scanning upward from its cursor, modulo 32. That operand's cursor then becomes the selected index plus one, modulo 32.
- R5: Each element writes the sum, modulo 2^XLEN, of the two resolved source registers into the resolved destination register. Elements run strictly in order, so an element reads any value an earlier element of the same instruction wrote.
- R6: A source bitmap with fewer set bits than the element count wraps around and reuses its physical registers in the same order.
- R7: If the destination or either source bitmap is all zeros, the instruction makes no register writes, keeps `busy` high for one cycle, and ends with `done` and `err` both high in the same cycle.
- R8: Physical register 0 always reads as zero. Element writes and preload writes aimed at it are dropped.
- R9: `busy` rises in the cycle after an accepted start. `done` is a one-cycle pulse that appears in the cycle after the last element is written, and `busy` falls in that same cycle.
- R10: A start pulse while `busy` is high is ignored and does not restart or change the running instruction.
- R11: Register preload writes (`rf_we`) take effect only while idle. The read port (`rf_raddr` to `rf_rdata`) is combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Bitmap write strobe |
| map_sel | input | 5 | Architectural register whose bitmap is written |
| map_bits | input | 32 | New bitmap value |
| rf_we | input | 1 | Register preload write strobe |
| rf_waddr | input | 5 | Preload physical address |
| rf_wdata | input | 32 | Preload data |
| rf_raddr | input | 5 | Read-port physical address |
| rf_rdata | output | 32 | Read-port data |
| start | input | 1 | Start an instruction |
| op_rd | input | 5 | Destination operand field |
| op_rs1 | input | 5 | First source operand field |
| op_rs2 | input | 5 | Second source operand field |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Empty bitmap met; valid with done |

## Verification
The hardest situations to reach from the ports are the ones where cursors wrap at different rates and an element reads a register that an earlier element of the same instruction wrote. Directed cases build bitmaps that overlap in these ways: one-bit sources under a multi-bit destination, a destination group that is also a source, and a group that holds bit 31 and physical register 0. Requests injected in the first busy cycle cover the ignored-while-busy rules: a stray start, an emptied bitmap and a preload. The effect of each is then looked for in the register file and in the next instruction. Random bitmaps with about four bits set, some of them empty, fill in the other overlaps.

// File: rtl/bmvadd_seq.sv
module bmvadd_seq #(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            map_we,
  input  logic [IW-1:0]   map_sel,
  input  logic [NREG-1:0] map_bits,
  input  logic            rf_we,
  input  logic [IW-1:0]   rf_waddr,
  input  logic [XLEN-1:0] rf_wdata,
  input  logic [IW-1:0]   rf_raddr,
  output logic [XLEN-1:0] rf_rdata,
  input  logic            start,
  input  logic [IW-1:0]   op_rd,
  input  logic [IW-1:0]   op_rs1,
  input  logic [IW-1:0]   op_rs2,
  output logic            busy,
  output logic            done,
  output logic            err
);

  logic [NREG-1:0] bmap [NREG];
  logic [XLEN-1:0] rf   [NREG];

  logic [IW-1:0] fd_q, fa_q, fb_q;
  logic [IW-1:0] cd_q, ca_q, cb_q;
  logic [CW-1:0] left_q;
  logic          fault_q, busy_q, done_q, err_q;

  function automatic logic [IW-1:0] pick(input logic [NREG-1:0] m, input logic [IW-1:0] cur);
    logic [IW-1:0] r;
    r = cur;
    for (int k = NREG - 1; k >= 0; k--)
      if (m[IW'(cur + IW'(k))]) r = IW'(cur + IW'(k));
    return r;
  endfunction

  function automatic logic [CW-1:0] popc(input logic [NREG-1:0] m);
    logic [CW-1:0] s;
    s = '0;
    for (int k = 0; k < NREG; k++) s = s + CW'(m[k]);
    return s;
  endfunction

  wire [IW-1:0] pd = pick(bmap[fd_q], cd_q);
  wire [IW-1:0] pa = pick(bmap[fa_q], ca_q);
  wire [IW-1:0] pb = pick(bmap[fb_q], cb_q);

  wire [XLEN-1:0] va  = (pa == '0) ? '0 : rf[pa];
  wire [XLEN-1:0] vb  = (pb == '0) ? '0 : rf[pb];
  wire [XLEN-1:0] sum = va + vb;

  wire go    = start && !busy_q;
  wire empty = ~|bmap[op_rd] | ~|bmap[op_rs1] | ~|bmap[op_rs2];
  wire step  = busy_q && !fault_q;

  assign rf_rdata = (rf_raddr == '0) ? '0 : rf[rf_raddr];
  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      fault_q <= 1'b0;
      left_q  <= '0;
      fd_q <= '0; fa_q <= '0; fb_q <= '0;
      cd_q <= '0; ca_q <= '0; cb_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (go) begin
        busy_q  <= 1'b1;
        fault_q <= empty;
        left_q  <= popc(bmap[op_rd]);
        fd_q <= op_rd; fa_q <= op_rs1; fb_q <= op_rs2;
        cd_q <= '0; ca_q <= '0; cb_q <= '0;
      end else if (busy_q) begin
        if (fault_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else begin
          cd_q   <= IW'(pd + 1'b1);
          ca_q   <= IW'(pa + 1'b1);
          cb_q   <= IW'(pb + 1'b1);
          left_q <= left_q - 1'b1;
          if (left_q == CW'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        bmap[i] <= NREG'(1) << i;
        rf[i]   <= '0;
      end
    end else begin
      if (map_we && !busy_q) bmap[map_sel] <= map_bits;
      if (step) begin
        if (pd != '0) rf[pd] <= sum;
      end else if (rf_we && !busy_q && rf_waddr != '0) begin
        rf[rf_waddr] <= rf_wdata;
      end
    end
  end

endmodule

// File: rtl/bmvadd_seq_chk.sv
module bmvadd_seq_chk #(
  parameter int IW = 5,
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic [IW-1:0]   rf_raddr,
  input logic [XLEN-1:0] rf_rdata
);

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9
  AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R7
  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_raddr == '0) |-> (rf_rdata == '0)); // R8
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> (busy || done)); // R10

endmodule

bind bmvadd_seq bmvadd_seq_chk #(.IW(IW), .XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
);

// File: tb/bmvadd_seq_tb.sv
`timescale 1ns/1ps
module bmvadd_seq_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, map_we, rf_we, start;
  logic [4:0] map_sel, rf_waddr, rf_raddr, op_rd, op_rs1, op_rs2;
  logic [31:0] map_bits, rf_wdata, rf_rdata;
  logic busy, done, err;

  bmvadd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_sel(map_sel), .map_bits(map_bits),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .start(start), .op_rd(op_rd), .op_rs1(op_rs1), .op_rs2(op_rs2),
    .busy(busy), .done(done), .err(err)
  );

  int checks = 0, errors = 0;
  logic [31:0] bm_m [32];
  logic [31:0] rf_m [32];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int next_member(logic [31:0] m, inout int c);
    int p = c;
    for (int t = 0; t < 32; t++) begin
      if (m[p]) begin
        c = (p + 1) % 32;
        return p;
      end
      p = (p + 1) % 32;
    end
    return 0;
  endfunction

  function automatic logic [31:0] rd_m(int p);
    return (p == 0) ? 32'h0 : rf_m[p];
  endfunction

  task automatic model_add(int d, int a, int b, output int n, output bit fe);
    int cd = 0, ca = 0, cb = 0;
    if (bm_m[d] == 0 || bm_m[a] == 0 || bm_m[b] == 0) begin
      fe = 1; n = 1; return;
    end
    fe = 0;
    n = $countones(bm_m[d]);
    for (int e = 0; e < n; e++) begin
      int pd, pa, pb;
      logic [31:0] s;
      pd = next_member(bm_m[d], cd);
      pa = next_member(bm_m[a], ca);
      pb = next_member(bm_m[b], cb);
      s = rd_m(pa) + rd_m(pb);
      if (pd != 0) rf_m[pd] = s;
    end
  endtask

  task automatic map_write(int idx, logic [31:0] m);
    @(negedge clk);
    map_we = 1; map_sel = 5'(idx); map_bits = m;
    @(negedge clk);
    map_we = 0;
    bm_m[idx] = m;
  endtask

  task automatic reg_write(int a, logic [31:0] v);
    @(negedge clk);
    rf_we = 1; rf_waddr = 5'(a); rf_wdata = v;
    @(negedge clk);
    rf_we = 0;
    if (a != 0) rf_m[a] = v;
  endtask

  task automatic check_rf(string req);
    for (int i = 0; i < 32; i++) begin
      rf_raddr = 5'(i);
      #0.5;
      chk(req, $sformatf("reg %0d", i), rf_rdata, rd_m(i));
    end
  endtask

  task automatic run(int d, int a, int b, bit inject, string req);
    int n, cnt;
    bit fe;
    model_add(d, a, b, n, fe);
    @(negedge clk);
    start = 1; op_rd = 5'(d); op_rs1 = 5'(a); op_rs2 = 5'(b);
    @(negedge clk);
    start = 0;
    chk("R9", "busy after start", {31'b0, busy}, 32'h1);
    if (inject) begin
      start = 1; op_rd = 5'd3; op_rs1 = 5'd1; op_rs2 = 5'd2;
      map_we = 1; map_sel = 5'd11; map_bits = 32'h0;
      rf_we = 1; rf_waddr = 5'd31; rf_wdata = 32'hDEAD_BEEF;
    end
    cnt = 0;
    while (!done && cnt < 64) begin
      cnt++;
      @(negedge clk);
      start = 0; map_we = 0; rf_we = 0;
    end
    start = 0; map_we = 0; rf_we = 0;
    chk("R3", "busy cycles", 32'(cnt), 32'(n));
    chk("R9", "done pulse", {31'b0, done}, 32'h1);
    chk("R9", "busy low at done", {31'b0, busy}, 32'h0);
    chk("R7", "err flag", {31'b0, err}, {31'b0, fe});
    @(negedge clk);
    chk("R9", "done single cycle", {31'b0, done}, 32'h0);
    chk("R10", "no restart", {31'b0, busy}, 32'h0);
    check_rf(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    rst_n = 0; map_we = 0; rf_we = 0; start = 0;
    map_sel = 0; map_bits = 0; rf_waddr = 0; rf_wdata = 0; rf_raddr = 0;
    op_rd = 0; op_rs1 = 0; op_rs2 = 0;
    for (int i = 0; i < 32; i++) begin
      bm_m[i] = 32'h1 << i;
      rf_m[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "busy reset", {31'b0, busy}, 0);
    chk("R1", "done reset", {31'b0, done}, 0);
    chk("R1", "err reset", {31'b0, err}, 0);
    check_rf("R1");

    reg_write(0, 32'h55);
    check_rf("R8 preload to reg0");
    reg_write(1, 32'd100); reg_write(2, 32'd23);
    run(3, 1, 2, 0, "R1 identity R5");

    for (int i = 4; i < 16; i++) reg_write(i, 32'(i * 7 + 1));
    map_write(10, 32'h0000_00F0);
    map_write(11, 32'h0000_0F00);
    map_write(12, 32'h0000_F000);
    run(10, 11, 12, 0, "R2 R4 groups");

    reg_write(20, 32'h11); reg_write(21, 32'h300); reg_write(22, 32'h4000);
    map_write(13, 32'h0010_0000);
    map_write(14, 32'h0060_0000);
    run(10, 13, 14, 0, "R6 source wrap");

    reg_write(16, 32'd5);
    map_write(15, 32'h0003_0000);
    run(15, 16, 16, 0, "R5 in-order dependency");

    reg_write(30, 32'hFFFF_FFF0); reg_write(1, 32'h25);
    map_write(17, 32'h8000_0003);
    map_write(18, 32'h4000_0002);
    run(17, 18, 18, 0, "R8 R5 reg0 dest and overflow");

    map_write(19, 32'h0);
    run(3, 19, 2, 0, "R7 empty source");
    run(19, 1, 2, 0, "R7 empty dest");

    map_write(11, 32'h0000_0F00);
    run(10, 11, 12, 1, "R10 R11 busy injection");
    run(10, 11, 12, 0, "R2 write during busy ignored");

    for (int it = 0; it < 60; it++) begin
      int d, a, b;
      for (int k = 20; k < 28; k++)
        if ($urandom_range(0, 2) == 0)
          map_write(k, ($urandom_range(0, 9) == 0) ? 32'h0 : ($urandom & $urandom & $urandom));
      for (int k = 0; k < 3; k++)
        reg_write($urandom_range(0, 31), $urandom);
      d = $urandom_range(20, 27);
      a = $urandom_range(20, 27);
      b = $urandom_range(20, 27);
      run(d, a, b, 0, "R3 R4 R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule